// File: doc/BRIEF.md
# Microstep Phase Sequencer

This block turns a step-clock input into the per-phase current commands for a two-phase bipolar stepper motor. It holds an 8-bit electrical-angle counter covering one full electrical cycle in 256 positions. Each captured step edge moves the angle forward or backward on the next internal-clock tick. The block decodes the angle into a sign, a 6-bit quarter-wave index and a scaled amplitude for each of phase A and phase B. A leads B by a quarter cycle when counting forward.

Step edges arrive asynchronously and are synchronized to the system clock. They are applied only on cycles where the internal divided-clock tick input is high. Two kinds of one-tick-period event come out as well: a per-phase step-down flag that can start a fast-decay interval, and an active-low monitor pulse at electrical-degree boundaries. The enable input blanks the amplitudes without freezing the counter. The sequence-reset input returns the block to its initial position and holds it there.

Top module: `ustep_phase_seq`

## Requirements
- R1: A rising edge on `step_in` changes the angle exactly once, at the first `int_tick` cycle after the edge has passed the synchronizer. With no tick, the outputs keep their values.
- R2: With `res_sel`=0 one step is 1/256 of a cycle. Phase A uses angle+64 and phase B uses the angle. Within each phase angle φ, the index is φ[5:0] when φ[6]=0 and its bitwise complement otherwise, so `a_idx` XOR `b_idx` is always 6'h3F.
- R3: With `res_sel`=1 one step is 32 positions (8 steps per cycle). Octants (φ[7:5]) 0 and 4 give index 0 and amplitude 0 with sign 0. Octants 2 and 6 give index 63 (100%). The other octants give index 31 (71%).
- R4: `dir_in`=0 counts the angle up and `dir_in`=1 counts it down, modulo 256.
- R5: While `enable_in`=0 both amplitudes and both step-down flags are 0. Steps still move the angle, and this shows on `a_idx`/`b_idx`. When enable returns, the amplitudes follow the accumulated angle.
- R6: While `seq_reset`=1 the angle is 0 (A index 63 positive, B index 0 positive), `mon_n` is 0, and step edges are dropped. This holds whatever `enable_in` is. After release, only a new rising edge on `step_in` moves the angle.
- R7: After a tick that applies a step, `mon_n` is low for one tick period if the new angle is a boundary. With `mon_sel`=1 a boundary is a multiple of 64; with `mon_sel`=0 it is angle 0. Otherwise `mon_n` is high.
- R8: The fine-mode level, in quarter-percent, is 10 (2.5%) at index 0, 284 (71%) at index 31 and 400 (100%) for indices 59 to 63. It is linear with truncation between those points: 10+274·i/31 for i≤31 and 284+116·(i−31)/28 for 32≤i≤58.
- R9: The amplitude is floor(level·(fs_code+1)/4). `fs_code` 0..3 thus gives 25%, 50%, 75% or 100% of the level.
- R10: After a tick that applies a step with enable high, a phase's step-down flag is 1 for one tick period if its new level is below its previous level. Otherwise it is 0.
- R11: A phase's sign output (1 = negative) is bit 7 of its phase angle, except at the coarse-mode zero octants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | Internal divided-clock enable, one clk cycle wide |
| step_in | input | 1 | Asynchronous step clock |
| enable_in | input | 1 | Output enable, 1 = amplitudes driven |
| dir_in | input | 1 | 0 = forward, 1 = reverse |
| seq_reset | input | 1 | Sequence reset, 1 = hold initial position |
| res_sel | input | 1 | 0 = 256-step cycle, 1 = 8-step cycle |
| mon_sel | input | 1 | 0 = monitor every 360 degrees, 1 = every 90 degrees |
| fs_code | input | 2 | Full-scale code 0..3 = 25..100% |
| a_neg | output | 1 | Phase A sign, 1 = negative |
| a_idx | output | 6 | Phase A quarter-wave index |
| a_amp | output | 9 | Phase A scaled amplitude, quarter-percent |
| a_down | output | 1 | Phase A step-down flag |
| b_neg | output | 1 | Phase B sign, 1 = negative |
| b_idx | output | 6 | Phase B quarter-wave index |
| b_amp | output | 9 | Phase B scaled amplitude, quarter-percent |
| b_down | output | 1 | Phase B step-down flag |
| mon_n | output | 1 | Active-low electrical-degree monitor |

## Verification
The bench builds the block with its default two-stage step synchronizer. That keeps each step to about a dozen clock cycles, so full 256-position sweeps fit in both directions and under both monitor intervals. Every table index is visited and every quarter-cycle and full-cycle crossing is checked. The coarse mode is swept over two full cycles forward and one in reverse. Each full-scale code is applied at several angles, and both the enable and reset orderings are exercised, including a reset while disabled.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int IDX_W       = 6;
  localparam int ANG_W       = IDX_W + 2;
  localparam int LVL_W       = 9;
  localparam int FS_W        = 2;
  localparam int AMP_W       = LVL_W;
  localparam int QUARTER     = 1 << IDX_W;
  localparam int COARSE_STEP = 1 << (IDX_W - 1);
  localparam int LVL_FULL    = 400;
  localparam int LVL_KNEE    = 284;
  localparam int LVL_FLOOR   = 10;
  localparam int IDX_KNEE    = 31;
  localparam int IDX_SAT     = 59;

  typedef struct packed {
    logic             neg;
    logic [IDX_W-1:0] idx;
    logic [LVL_W-1:0] lvl;
  } phase_t;

  // quarter-wave level in quarter-percent units, piecewise linear
  function automatic logic [LVL_W-1:0] quarter_level(input logic [IDX_W-1:0] i);
    int v;
    int k;
    k = int'(i);
    if (k >= IDX_SAT)
      v = LVL_FULL;
    else if (k <= IDX_KNEE)
      v = LVL_FLOOR + (k * (LVL_KNEE - LVL_FLOOR)) / IDX_KNEE;
    else
      v = LVL_KNEE + ((k - IDX_KNEE) * (LVL_FULL - LVL_KNEE)) / (IDX_SAT - IDX_KNEE);
    return LVL_W'(v);
  endfunction

  function automatic phase_t decode_phase(input logic [ANG_W-1:0] phi, input logic coarse);
    phase_t r;
    logic [IDX_W-1:0] p;
    r   = '0;
    p   = phi[IDX_W-1:0];
    r.neg = phi[ANG_W-1];
    if (coarse) begin
      unique case (phi[ANG_W-2:ANG_W-3])
        2'b00: begin
          r.idx = '0;
          r.lvl = '0;
          r.neg = 1'b0;
        end
        2'b10: begin
          r.idx = '1;
          r.lvl = LVL_W'(LVL_FULL);
        end
        default: begin
          r.idx = IDX_W'(IDX_KNEE);
          r.lvl = quarter_level(IDX_W'(IDX_KNEE));
        end
      endcase
    end else begin
      r.idx = phi[ANG_W-2] ? ~p : p;
      r.lvl = quarter_level(r.idx);
    end
    return r;
  endfunction

  function automatic logic [AMP_W-1:0] scale_amp(input logic [LVL_W-1:0] lvl,
                                                 input logic [FS_W-1:0]  fs);
    int v;
    v = (int'(lvl) * (int'(fs) + 1)) >> FS_W;
    return AMP_W'(v);
  endfunction

  function automatic logic [ANG_W-1:0] step_delta(input logic coarse, input logic dir);
    logic [ANG_W-1:0] m;
    m = coarse ? ANG_W'(COARSE_STEP) : ANG_W'(1);
    return dir ? (~m + ANG_W'(1)) : m;
  endfunction

  function automatic logic at_boundary(input logic [ANG_W-1:0] ang, input logic every_quarter);
    return every_quarter ? (ang[IDX_W-1:0] == '0) : (ang == '0);
  endfunction
endpackage

// File: rtl/ustep_edge_capture.sv
module ustep_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic tick,
  input  logic clear,
  output logic take
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic            pending;
  logic            rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], step_in};
  end

  assign rise = sh[SH_W-2] & ~sh[SH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pending <= 1'b0;
    else if (clear) pending <= 1'b0;
    else if (rise)  pending <= 1'b1;
    else if (tick)  pending <= 1'b0;
  end

  assign take = pending & tick & ~clear;
endmodule

// File: rtl/ustep_angle_track.sv
module ustep_angle_track
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             take,
  input  logic             clear,
  input  logic             dir,
  input  logic             coarse,
  input  logic             mon_sel,
  output logic [ANG_W-1:0] angle,
  output logic [ANG_W-1:0] angle_nxt,
  output logic             mon_n
);
  logic mon_q;

  assign angle_nxt = angle + step_delta(coarse, dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle <= '0;
      mon_q <= 1'b0;
    end else if (clear) begin
      angle <= '0;
      mon_q <= 1'b0;
    end else if (tick) begin
      mon_q <= take & at_boundary(angle_nxt, mon_sel);
      if (take) angle <= angle_nxt;
    end
  end

  assign mon_n = ~(mon_q | clear);
endmodule

// File: rtl/ustep_phase_shaper.sv
module ustep_phase_shaper
  import ustep_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             take,
  input  logic             clear,
  input  logic             enable,
  input  logic             coarse,
  input  logic [FS_W-1:0]  fs,
  input  logic [ANG_W-1:0] angle,
  input  logic [ANG_W-1:0] angle_nxt,
  output logic             neg,
  output logic [IDX_W-1:0] idx,
  output logic [AMP_W-1:0] amp,
  output logic             down
);
  localparam logic [ANG_W-1:0] OFS = ANG_W'(OFFSET);

  phase_t cur;
  phase_t nxt;
  logic   down_q;

  assign cur = decode_phase(angle + OFS, coarse);
  assign nxt = decode_phase(angle_nxt + OFS, coarse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     down_q <= 1'b0;
    else if (clear) down_q <= 1'b0;
    else if (tick)  down_q <= take & enable & (nxt.lvl < cur.lvl);
  end

  assign neg  = cur.neg;
  assign idx  = cur.idx;
  assign amp  = enable ? scale_amp(cur.lvl, fs) : '0;
  assign down = down_q;
endmodule

// File: rtl/ustep_phase_seq.sv
module ustep_phase_seq
  import ustep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_tick,
  input  logic             step_in,
  input  logic             enable_in,
  input  logic             dir_in,
  input  logic             seq_reset,
  input  logic             res_sel,
  input  logic             mon_sel,
  input  logic [FS_W-1:0]  fs_code,
  output logic             a_neg,
  output logic [IDX_W-1:0] a_idx,
  output logic [AMP_W-1:0] a_amp,
  output logic             a_down,
  output logic             b_neg,
  output logic [IDX_W-1:0] b_idx,
  output logic [AMP_W-1:0] b_amp,
  output logic             b_down,
  output logic             mon_n
);
  localparam int NPH = 2;

  logic             step_take;
  logic [ANG_W-1:0] angle_q;
  logic [ANG_W-1:0] angle_nxt;

  logic             ph_neg  [NPH];
  logic [IDX_W-1:0] ph_idx  [NPH];
  logic [AMP_W-1:0] ph_amp  [NPH];
  logic             ph_down [NPH];

  ustep_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_in (step_in),
    .tick    (int_tick),
    .clear   (seq_reset),
    .take    (step_take)
  );

  ustep_angle_track u_ang (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (int_tick),
    .take      (step_take),
    .clear     (seq_reset),
    .dir       (dir_in),
    .coarse    (res_sel),
    .mon_sel   (mon_sel),
    .angle     (angle_q),
    .angle_nxt (angle_nxt),
    .mon_n     (mon_n)
  );

  // phase 0 = A (quarter cycle ahead), phase 1 = B
  for (genvar g = 0; g < NPH; g++) begin : g_phase
    ustep_phase_shaper #(.OFFSET((g == 0) ? QUARTER : 0)) u_shp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (int_tick),
      .take      (step_take),
      .clear     (seq_reset),
      .enable    (enable_in),
      .coarse    (res_sel),
      .fs        (fs_code),
      .angle     (angle_q),
      .angle_nxt (angle_nxt),
      .neg       (ph_neg[g]),
      .idx       (ph_idx[g]),
      .amp       (ph_amp[g]),
      .down      (ph_down[g])
    );
  end

  assign a_neg  = ph_neg[0];
  assign a_idx  = ph_idx[0];
  assign a_amp  = ph_amp[0];
  assign a_down = ph_down[0];
  assign b_neg  = ph_neg[1];
  assign b_idx  = ph_idx[1];
  assign b_amp  = ph_amp[1];
  assign b_down = ph_down[1];
endmodule

// File: rtl/ustep_phase_seq_chk.sv
module ustep_phase_seq_chk
  import ustep_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             take,
  input logic             enable_in,
  input logic             dir_in,
  input logic             seq_reset,
  input logic             res_sel,
  input logic [ANG_W-1:0] angle,
  input logic             a_neg,
  input logic [IDX_W-1:0] a_idx,
  input logic [AMP_W-1:0] a_amp,
  input logic             a_down,
  input logic             b_neg,
  input logic [IDX_W-1:0] b_idx,
  input logic [AMP_W-1:0] b_amp,
  input logic             mon_n
);
  p_hold_without_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !seq_reset) |=> $stable(angle));

  p_fine_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !seq_reset && !res_sel && !dir_in) |=> (angle == ANG_W'($past(angle) + 1)));

  p_quadrature_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_sel |-> ((a_idx ^ b_idx) == {IDX_W{1'b1}}));

  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_in |-> (a_amp == '0 && b_amp == '0));

  p_reset_initial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |=> (a_idx == '1 && b_idx == '0 && !a_neg && !b_neg));

  p_mon_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mon_n) && !seq_reset) |-> $past(tick));

  p_down_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_down) |-> $past(tick));
endmodule

bind ustep_phase_seq ustep_phase_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (int_tick),
  .take      (step_take),
  .enable_in (enable_in),
  .dir_in    (dir_in),
  .seq_reset (seq_reset),
  .res_sel   (res_sel),
  .angle     (angle_q),
  .a_neg     (a_neg),
  .a_idx     (a_idx),
  .a_amp     (a_amp),
  .a_down    (a_down),
  .b_neg     (b_neg),
  .b_idx     (b_idx),
  .b_amp     (b_amp),
  .mon_n     (mon_n)
);

// File: tb/test_ustep_phase_seq.sv
`timescale 1ns/1ps
module test_ustep_phase_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_tick = 1'b0;
  logic       step_in = 1'b0;
  logic       enable_in = 1'b1;
  logic       dir_in = 1'b0;
  logic       seq_reset = 1'b0;
  logic       res_sel = 1'b0;
  logic       mon_sel = 1'b1;
  logic [1:0] fs_code = 2'd3;
  logic       a_neg, b_neg, a_down, b_down, mon_n;
  logic [5:0] a_idx, b_idx;
  logic [8:0] a_amp, b_amp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_ang = 0;

  always #2.5 clk = ~clk;

  ustep_phase_seq i_ustep_phase_seq (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .step_in(step_in),
    .enable_in(enable_in), .dir_in(dir_in), .seq_reset(seq_reset),
    .res_sel(res_sel), .mon_sel(mon_sel), .fs_code(fs_code),
    .a_neg(a_neg), .a_idx(a_idx), .a_amp(a_amp), .a_down(a_down),
    .b_neg(b_neg), .b_idx(b_idx), .b_amp(b_amp), .b_down(b_down),
    .mon_n(mon_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (angle %0d)", req, act, exp, m_ang);
    end
  endtask

  // R8 level restated with the knee points as slopes
  function automatic int exp_lvl(input int i);
    if (i > 58) return 400;
    if (i < 32) return 10 + (i * 274) / 31;
    return 284 + ((i - 31) * 116) / 28;
  endfunction

  function automatic void exp_phase(input int phi, input bit coarse,
                                    output int idx, output int lvl, output bit neg);
    int q, p, oct;
    q = (phi / 64) % 4;
    p = phi % 64;
    neg = (phi >= 128);
    if (coarse) begin
      oct = (phi / 32) % 4;
      if (oct == 0) begin idx = 0; lvl = 0; neg = 1'b0; end
      else if (oct == 2) begin idx = 63; lvl = 400; end
      else begin idx = 31; lvl = exp_lvl(31); end
    end else begin
      idx = (q == 1 || q == 3) ? 63 - p : p;
      lvl = exp_lvl(idx);
    end
  endfunction

  task automatic check_all(input string req, input bit flags, input bit stepped,
                           input int pa, input int pb);
    int ia, la, ib, lb, ea, eb;
    bit na, nb, bnd;
    exp_phase((m_ang + 64) % 256, res_sel, ia, la, na);
    exp_phase(m_ang, res_sel, ib, lb, nb);
    ea = enable_in ? (la * (int'(fs_code) + 1)) / 4 : 0;
    eb = enable_in ? (lb * (int'(fs_code) + 1)) / 4 : 0;
    check(int'(a_idx) == ia, {req, " a_idx"}, int'(a_idx), ia);
    check(int'(b_idx) == ib, {req, " b_idx"}, int'(b_idx), ib);
    check(a_neg == na, {req, " R11 a_neg"}, int'(a_neg), int'(na));
    check(b_neg == nb, {req, " R11 b_neg"}, int'(b_neg), int'(nb));
    check(int'(a_amp) == ea, {req, " R9 a_amp"}, int'(a_amp), ea);
    check(int'(b_amp) == eb, {req, " R9 b_amp"}, int'(b_amp), eb);
    if (flags) begin
      bnd = stepped && (mon_sel ? (m_ang % 64 == 0) : (m_ang == 0));
      check(mon_n == !bnd, {req, " R7 mon_n"}, int'(mon_n), int'(!bnd));
      check(a_down == (stepped && enable_in && la < pa), {req, " R10 a_down"},
            int'(a_down), int'(stepped && enable_in && la < pa));
      check(b_down == (stepped && enable_in && lb < pb), {req, " R10 b_down"},
            int'(b_down), int'(stepped && enable_in && lb < pb));
    end
  endtask

  task automatic tick_once();
    @(negedge clk) int_tick = 1'b1;
    @(negedge clk) int_tick = 1'b0;
  endtask

  task automatic step_edge();
    @(negedge clk) step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_step(input string req);
    int ia, pa, ib, pb, s;
    bit n;
    exp_phase((m_ang + 64) % 256, res_sel, ia, pa, n);
    exp_phase(m_ang, res_sel, ib, pb, n);
    step_edge();
    tick_once();
    s = res_sel ? 32 : 1;
    m_ang = (m_ang + (dir_in ? 256 - s : s)) % 256;
    check_all(req, 1'b1, 1'b1, pa, pb);
  endtask

  task automatic pulse_seq_reset();
    @(negedge clk) seq_reset = 1'b1;
    @(negedge clk) seq_reset = 1'b0;
    m_ang = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R6 reset state", 1'b1, 1'b0, 0, 0);

    // R1: edge without tick leaves outputs, tick then applies it once
    step_edge();
    check_all("R1 no tick", 1'b0, 1'b0, 0, 0);
    tick_once();
    m_ang = 1;
    check_all("R1 tick applies", 1'b0, 1'b0, 0, 0);
    tick_once();
    check_all("R1 single step", 1'b1, 1'b0, 0, 0);

    // R2 R7 R8 R10: full fine sweep forward, 90-degree monitor
    for (int k = 0; k < 256; k++) do_step("R2 fine fwd");

    // R4 R7: full fine sweep reverse, 360-degree monitor
    dir_in = 1'b1;
    mon_sel = 1'b0;
    for (int k = 0; k < 256; k++) do_step("R4 fine rev");

    // R9: each full-scale code over several steps
    dir_in = 1'b0;
    for (int f = 0; f < 4; f++) begin
      fs_code = 2'(f);
      @(negedge clk);
      check_all("R9 fs code", 1'b0, 1'b0, 0, 0);
      for (int k = 0; k < 5; k++) do_step("R9 fs step");
    end

    // R3: coarse mode from the initial position
    pulse_seq_reset();
    res_sel = 1'b1;
    mon_sel = 1'b1;
    @(negedge clk);
    check_all("R3 coarse init", 1'b0, 1'b0, 0, 0);
    for (int k = 0; k < 16; k++) do_step("R3 coarse fwd");
    dir_in = 1'b1;
    for (int k = 0; k < 8; k++) do_step("R3 coarse rev");
    dir_in = 1'b0;

    // R5: disabled outputs, counter keeps moving
    enable_in = 1'b0;
    for (int k = 0; k < 5; k++) do_step("R5 disabled");
    enable_in = 1'b1;
    @(negedge clk);
    check_all("R5 resume", 1'b0, 1'b0, 0, 0);

    // R6: reset holds, drops edges, needs a new edge after release
    @(negedge clk) seq_reset = 1'b1;
    m_ang = 0;
    @(negedge clk);
    check(mon_n == 1'b0, "R6 mon low in reset", int'(mon_n), 0);
    check_all("R6 held", 1'b0, 1'b0, 0, 0);
    step_edge();
    tick_once();
    check_all("R6 edge dropped", 1'b0, 1'b0, 0, 0);
    @(negedge clk) step_in = 1'b1;
    repeat (4) @(negedge clk);
    seq_reset = 1'b0;
    repeat (4) @(negedge clk);
    tick_once();
    check_all("R6 no edge after release", 1'b1, 1'b0, 0, 0);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    do_step("R6 restart");

    // R6: reset while disabled clears the counter
    enable_in = 1'b0;
    for (int k = 0; k < 3; k++) do_step("R5 disabled pre-reset");
    pulse_seq_reset();
    enable_in = 1'b1;
    @(negedge clk);
    check_all("R6 cleared while disabled", 1'b0, 1'b0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule